// File: doc/BRIEF.md
# Integer to Single-Precision Converter

This scalar unit turns a signed integer into an IEEE-754 single-precision number and writes it into the lowest 32-bit lane of a wide vector destination. The integer is taken as a signed 32-bit value unless the core is in 64-bit mode and the operand is 64 bits wide. In that case all 64 bits are converted. A value too wide for the 24-bit significand is rounded in one of four directions, and the unit raises a precision flag when it does.

The rounding direction normally comes from a global control field. One case is different: for the third encoding class with a register source and embedded rounding enabled, the instruction's own rounding field is used instead. The lanes above the result depend on the encoding class. The legacy class keeps the old destination contents. The two newer classes copy bits 127:32 from a first vector source and clear everything from bit 128 upward. A start pulse loads the registered result, and valid follows one cycle later.

Top module: `int2sp_cvt`

## Requirements
- R1: `valid` is high in exactly the cycle after a `start` pulse. In a cycle with no `start`, `dst` and `inexact` keep their values.
- R2: The full 64-bit source is converted only when `mode64` and `opsize64` are both 1. Otherwise only `src_int[31:0]` is used, read as a signed 32-bit value, and the upper 32 bits have no effect.
- R3: Any integer with magnitude below 2^24 converts exactly. The sign bit equals the integer's sign, and `inexact` is 0.
- R4: Rounding code 2'b00 rounds to nearest. A tie goes to the even significand.
- R5: Rounding code 2'b01 rounds toward negative infinity. Code 2'b10 rounds toward positive infinity. Code 2'b11 truncates toward zero.
- R6: The rounding code is `emb_rc` when `enc_class` is 2'b10 (the third class), `src_is_reg` is 1 and `emb_rc_en` is 1. In every other case it is `glob_rc`.
- R7: `inexact` is 1 exactly when a discarded bit of the magnitude was nonzero.
- R8: A zero input gives +0.0 (32'h00000000) with `inexact` at 0.
- R9: The most negative 32-bit input converts exactly to 32'hCF000000. The most negative 64-bit input, in wide form, converts exactly to 32'hDF000000.
- R10: With `enc_class` 2'b00 (legacy), `dst[VLEN-1:32]` equals `old_dst[VLEN-1:32]`.
- R11: With any other `enc_class`, `dst[127:32]` equals `vsrc1[127:32]` and `dst[VLEN-1:128]` is zero.
- R12: If rounding carries out of the 24-bit significand, the exponent goes up by one and the fraction becomes zero. For example, 33554431 rounded to nearest gives 32'h4C000000.
- R13: After reset, `dst`, `valid` and `inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads one conversion |
| src_int | input | 64 | Integer source |
| mode64 | input | 1 | Core is in 64-bit mode |
| opsize64 | input | 1 | Operand size is 64 bits |
| enc_class | input | 2 | 00 legacy, 01 second class, 10 third class, 11 treated as 01 |
| src_is_reg | input | 1 | Integer source is a register |
| emb_rc_en | input | 1 | Embedded rounding enable |
| emb_rc | input | 2 | Embedded rounding code |
| glob_rc | input | 2 | Global rounding code |
| vsrc1 | input | VLEN | First vector source |
| old_dst | input | VLEN | Previous destination value |
| dst | output | VLEN | Merged destination |
| valid | output | 1 | Result valid |
| inexact | output | 1 | Precision flag |

## Verification
The bench targets the following corner cases:
- **Round-to-nearest ties.** 2^24+1 and 2^24+3 are ties with an even and an odd significand. A unit that always rounds half up would be wrong on the first one.
- **Significand carry-out.** 33554431 carries out of the significand. A unit that ignores the carry would produce a zero fraction with the exponent left too small.
- **Integer minimums.** The 32-bit and 64-bit minimums expose an absolute value that overflows.
- **Width selection.** Values whose upper 32 bits are junk show whether the wide form leaks in outside 64-bit mode.
- **Rounding source.** Switching between embedded and global rounding across classes and source kinds catches a selector that ignores the register-source or class condition.
- **Upper lanes.** Distinct patterns in the vector source and the old destination show whether the upper lanes were merged from the wrong input.

// File: rtl/int2sp_cvt.sv
module int2sp_cvt #(
  parameter int VLEN = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [63:0]     src_int,
  input  logic            mode64,
  input  logic            opsize64,
  input  logic [1:0]      enc_class,
  input  logic            src_is_reg,
  input  logic            emb_rc_en,
  input  logic [1:0]      emb_rc,
  input  logic [1:0]      glob_rc,
  input  logic [VLEN-1:0] vsrc1,
  input  logic [VLEN-1:0] old_dst,
  output logic [VLEN-1:0] dst,
  output logic            valid,
  output logic            inexact
);
  localparam logic [1:0] ENC_LEGACY = 2'b00;
  localparam logic [1:0] ENC_THIRD  = 2'b10;
  localparam int         SIG_W      = 24;
  localparam int         LOW_W      = 64 - SIG_W - 1;

  logic        wide, neg, grd, stk, inx, up, zero;
  logic [63:0] val, mag, norm;
  logic [5:0]  msb;
  logic [1:0]  rc;
  logic [SIG_W-1:0] sig;
  logic [SIG_W:0]   rsum;
  logic [7:0]  expo;
  logic [22:0] frac;
  logic [31:0] res;
  logic [VLEN-1:0] nxt;

  assign wide = mode64 & opsize64;
  assign val  = wide ? src_int : {{32{src_int[31]}}, src_int[31:0]};
  assign neg  = val[63];
  assign mag  = neg ? (~val + 64'd1) : val;
  assign zero = (mag == 64'd0);

  always_comb begin
    msb = '0;
    for (int i = 0; i < 64; i++)
      if (mag[i]) msb = i[5:0];
  end

  assign norm = mag << (6'd63 - msb);
  assign sig  = norm[63 -: SIG_W];
  assign grd  = norm[LOW_W];
  assign stk  = |norm[LOW_W-1:0];
  assign inx  = grd | stk;

  assign rc = (enc_class == ENC_THIRD && src_is_reg && emb_rc_en) ? emb_rc : glob_rc;

  always_comb begin
    case (rc)
      2'b00:   up = grd & (stk | sig[0]);
      2'b01:   up = neg & inx;
      2'b10:   up = ~neg & inx;
      default: up = 1'b0;
    endcase
  end

  assign rsum = {1'b0, sig} + {{SIG_W{1'b0}}, up};
  assign expo = 8'd127 + {2'b00, msb} + {7'd0, rsum[SIG_W]};
  assign frac = rsum[SIG_W] ? rsum[SIG_W-1:1] : rsum[SIG_W-2:0];
  assign res  = zero ? 32'd0 : {neg, expo, frac};

  always_comb begin
    if (enc_class == ENC_LEGACY) begin
      nxt = old_dst;
    end else begin
      nxt = '0;
      nxt[127:32] = vsrc1[127:32];
    end
    nxt[31:0] = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst     <= '0;
      valid   <= 1'b0;
      inexact <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        dst     <= nxt;
        inexact <= inx & ~zero;
      end
    end
  end
endmodule

// File: rtl/int2sp_cvt_chk.sv
module int2sp_cvt_chk #(
  parameter int VLEN = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [63:0]     src_int,
  input logic            mode64,
  input logic            opsize64,
  input logic [1:0]      enc_class,
  input logic [VLEN-1:0] vsrc1,
  input logic [VLEN-1:0] old_dst,
  input logic [VLEN-1:0] dst,
  input logic            valid,
  input logic            inexact
);
  logic w, sgn, is_zero, min64;
  assign w       = mode64 & opsize64;
  assign sgn     = w ? src_int[63] : src_int[31];
  assign is_zero = w ? (src_int == 64'd0) : (src_int[31:0] == 32'd0);
  assign min64   = w && (src_int == 64'h8000_0000_0000_0000);

  assert_valid_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!valid && $stable(dst) && $stable(inexact)));
  assert_sign_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_zero) |=> dst[31] == $past(sgn));
  assert_zero_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_zero) |=> (dst[31:0] == 32'd0 && !inexact));
  assert_min64_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && min64) |=> (dst[31:0] == 32'hDF00_0000 && !inexact));
  assert_legacy_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && enc_class == 2'b00) |=> dst[VLEN-1:32] == $past(old_dst[VLEN-1:32]));
  assert_vec_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && enc_class != 2'b00) |=>
      (dst[127:32] == $past(vsrc1[127:32]) && dst[VLEN-1:128] == '0));
endmodule

bind int2sp_cvt int2sp_cvt_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_int(src_int),
  .mode64(mode64), .opsize64(opsize64), .enc_class(enc_class),
  .vsrc1(vsrc1), .old_dst(old_dst), .dst(dst), .valid(valid), .inexact(inexact)
);

// File: tb/int2sp_cvt_tb.sv
module int2sp_cvt_tb;
  localparam int VLEN = 512;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] src_int = '0;
  logic mode64 = 1'b0, opsize64 = 1'b0, src_is_reg = 1'b0, emb_rc_en = 1'b0;
  logic [1:0] enc_class = '0, emb_rc = '0, glob_rc = '0;
  logic [VLEN-1:0] vsrc1, old_dst;
  logic [VLEN-1:0] dst;
  logic valid, inexact;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  int2sp_cvt #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_int(src_int),
    .mode64(mode64), .opsize64(opsize64), .enc_class(enc_class),
    .src_is_reg(src_is_reg), .emb_rc_en(emb_rc_en), .emb_rc(emb_rc),
    .glob_rc(glob_rc), .vsrc1(vsrc1), .old_dst(old_dst),
    .dst(dst), .valid(valid), .inexact(inexact)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One conversion; checks the low lane, the flag and the upper lanes
  task automatic cvt(input logic [63:0] s, input bit m64, input bit os, input logic [1:0] enc,
                     input bit rg, input bit een, input logic [1:0] erc, input logic [1:0] grc,
                     input logic [31:0] ev, input bit ei, input string tag);
    logic [VLEN-1:0] up_exp;
    @(negedge clk);
    src_int = s; mode64 = m64; opsize64 = os; enc_class = enc;
    src_is_reg = rg; emb_rc_en = een; emb_rc = erc; glob_rc = grc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(valid === 1'b1, "R1 valid", {63'd0, valid}, 64'd1);
    chk(dst[31:0] === ev && inexact === ei, tag, {31'd0, inexact, dst[31:0]}, {31'd0, ei, ev});
    if (enc == 2'b00) begin
      up_exp = old_dst;
      chk(dst[VLEN-1:32] === up_exp[VLEN-1:32], "R10 legacy upper", dst[95:32], up_exp[95:32]);
    end else begin
      up_exp = '0;
      up_exp[127:32] = vsrc1[127:32];
      chk(dst[VLEN-1:32] === up_exp[VLEN-1:32], "R11 vector upper", dst[191:128], up_exp[191:128]);
    end
  endtask

  task automatic t_reset;
    chk(dst === '0 && valid === 1'b0 && inexact === 1'b0, "R13 reset", {62'd0, valid, inexact}, 64'd0);
  endtask

  task automatic t_exact;
    cvt(64'd1, 0, 0, 2'b01, 1, 0, 2'b00, 2'b00, 32'h3F80_0000, 0, "R3 +1");
    cvt(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2'b01, 1, 0, 2'b00, 2'b11, 32'hBF80_0000, 0, "R3 -1 wide");
    cvt(64'd5, 0, 0, 2'b00, 1, 0, 2'b00, 2'b10, 32'h40A0_0000, 0, "R3 5");
  endtask

  task automatic t_width;
    cvt(64'h0000_0001_0000_0005, 1, 1, 2'b01, 1, 0, 2'b00, 2'b00, 32'h4F80_0000, 1, "R2 wide form");
    cvt(64'h0000_0001_0000_0005, 0, 1, 2'b01, 1, 0, 2'b00, 2'b00, 32'h40A0_0000, 0, "R2 wide outside 64-bit mode");
    cvt(64'h1234_5678_FFFF_FFFF, 1, 0, 2'b10, 1, 0, 2'b00, 2'b00, 32'hBF80_0000, 0, "R2 narrow operand");
  endtask

  task automatic t_rne;
    cvt(64'd16777217, 0, 0, 2'b00, 1, 0, 2'b00, 2'b00, 32'h4B80_0000, 1, "R4 tie to even down");
    cvt(64'd16777219, 0, 0, 2'b00, 1, 0, 2'b00, 2'b00, 32'h4B80_0002, 1, "R4 tie to even up");
  endtask

  task automatic t_directed;
    cvt(64'd16777217, 0, 0, 2'b01, 1, 0, 2'b00, 2'b10, 32'h4B80_0001, 1, "R5 +inf positive");
    cvt(64'd16777217, 0, 0, 2'b01, 1, 0, 2'b00, 2'b01, 32'h4B80_0000, 1, "R5 -inf positive");
    cvt(-64'sd16777217, 0, 0, 2'b01, 1, 0, 2'b00, 2'b01, 32'hCB80_0001, 1, "R5 -inf negative");
    cvt(-64'sd16777217, 0, 0, 2'b01, 1, 0, 2'b00, 2'b10, 32'hCB80_0000, 1, "R5 +inf negative");
    cvt(64'd33554431, 0, 0, 2'b01, 1, 0, 2'b00, 2'b11, 32'h4BFF_FFFF, 1, "R5 toward zero");
  endtask

  task automatic t_rc_select;
    cvt(64'd16777217, 0, 0, 2'b10, 1, 1, 2'b10, 2'b00, 32'h4B80_0001, 1, "R6 embedded used");
    cvt(64'd16777217, 0, 0, 2'b10, 0, 1, 2'b10, 2'b00, 32'h4B80_0000, 1, "R6 memory source uses global");
    cvt(64'd16777217, 0, 0, 2'b01, 1, 1, 2'b10, 2'b00, 32'h4B80_0000, 1, "R6 second class uses global");
    cvt(64'd16777217, 0, 0, 2'b10, 1, 0, 2'b10, 2'b00, 32'h4B80_0000, 1, "R6 enable off uses global");
  endtask

  task automatic t_inexact;
    cvt(64'd16777216, 0, 0, 2'b00, 1, 0, 2'b00, 2'b00, 32'h4B80_0000, 0, "R7 exact 2^24 no flag");
    cvt(64'h0000_0001_0000_0005, 1, 1, 2'b00, 1, 0, 2'b00, 2'b11, 32'h4F80_0000, 1, "R7 sticky only");
  endtask

  task automatic t_zero;
    cvt(64'd0, 1, 1, 2'b10, 1, 1, 2'b01, 2'b01, 32'h0000_0000, 0, "R8 zero");
    cvt(64'h0000_0001_0000_0000, 0, 1, 2'b00, 1, 0, 2'b00, 2'b00, 32'h0000_0000, 0, "R8 zero low half");
  endtask

  task automatic t_minneg;
    cvt(64'h0000_0000_8000_0000, 1, 0, 2'b01, 1, 0, 2'b00, 2'b00, 32'hCF00_0000, 0, "R9 min 32-bit");
    cvt(64'h8000_0000_0000_0000, 1, 1, 2'b01, 1, 0, 2'b00, 2'b00, 32'hDF00_0000, 0, "R9 min 64-bit");
  endtask

  task automatic t_carry;
    cvt(64'd33554431, 0, 0, 2'b11, 1, 0, 2'b00, 2'b00, 32'h4C00_0000, 1, "R12 carry out nearest");
    cvt(-64'sd33554431, 0, 0, 2'b00, 1, 0, 2'b00, 2'b01, 32'hCC00_0000, 1, "R12 carry out -inf");
  endtask

  task automatic t_hold;
    logic [VLEN-1:0] snap;
    snap = dst;
    @(negedge clk);
    src_int = 64'd77; enc_class = 2'b00;
    @(negedge clk);
    chk(valid === 1'b0, "R1 valid drops", {63'd0, valid}, 64'd0);
    chk(dst === snap, "R1 dst holds", dst[63:0], snap[63:0]);
  endtask

  initial begin
    for (int i = 0; i < VLEN / 32; i++) begin
      vsrc1[i*32 +: 32]   = 32'hA500_0000 + i;
      old_dst[i*32 +: 32] = 32'h5C00_0000 + i;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_exact();
    t_width();
    t_rne();
    t_directed();
    t_rc_select();
    t_inexact();
    t_zero();
    t_minneg();
    t_carry();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule